// File: doc/BRIEF.md
# Parallel Signal Serial Mirroring Port

The block copies a group of parallel signals to a remote device over a serial master link and brings the remote device's returned signals back as parallel outputs. It has one serial clock, one active-low select and one data line in each direction. On every system clock a sample register captures the parallel input pins. A source selector then offers either that sample or a word written by software as the next frame. The serial engine compares the offered frame with a register that holds the last frame sent. It runs a transfer only when the two differ, or when software asks for one.

While a frame shifts out, the returned bits shift in. The received frame is copied in one step to a deserialized register, and that register drives the parallel outputs. Software reaches the control word, the alternate word, the last-sent copy and the deserialized word through a small register bus. Writes take one cycle and reads are combinational. The frame length can be set from 4 to 32 bits.

Top module: `pinmirror_port`

## Requirements
- R1: With the source bit at 0, the frame sent is the parallel input word as sampled by a register on every system clock.
- R2: The control word at bus address 0 holds the source bit at bit 8. When it is 1, the frame comes from the alternate register at address 1, and changes on the input pins cause no transfer.
- R3: Control bits [5:0] set the frame length. A value below 4 acts as 4 and a value above 32 acts as 32. Bits go out most significant first, starting at bit length-1. Bits at or above the length never start a transfer and read as 0 in the last-sent and deserialized registers.
- R4: A transfer starts only while the link is idle and the selected source, masked to the length, differs from the last-sent register. Otherwise the select line stays high.
- R5: Writing 1 to control bit 9 forces exactly one transfer even when the data is unchanged. The bit reads back as 0.
- R6: The last-sent register, read at address 2, takes the masked frame when that frame completes. It changes at no other time.
- R7: The deserialized register, read at address 3, and the parallel outputs take the whole received frame in the cycle the select line is released. The first bit received lands at bit length-1. They never show a partial frame.
- R8: The serial clock idles low. Each half period lasts HALF_DIV system clocks. Output data changes only on rising clock edges, and input data is sampled on falling edges.
- R9: The select line falls one half period before the first rising clock edge. It rises one half period after the last falling edge.
- R10: Between frames the select line stays high for at least GAP_HALVES half periods (two serial clock periods by default). A frame whose data changes mid-transfer is followed by a second frame that carries the new data.
- R11: After reset the select line is high, the serial clock and data are low, and the alternate, last-sent and deserialized registers are 0. The length field reads 32 and the source bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_in | input | 32 | Parallel signals to be mirrored |
| pins_out | output | 32 | Parallel signals from the last received frame |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 alternate, 2 last-sent, 3 deserialized |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low frame select |
| sdo | output | 1 | Serial data to the remote device |
| sdi | input | 1 | Serial data from the remote device |

## Verification
The bench acts as the remote device and measures every half period and the select-line lead, tail and gap in system clocks. A divider or sequencing slip shows up as a wrong interval rather than a wrong word. It changes only bits above a short frame length and shrinks the length to a value that clamps onto equal masked data. A design that masked the wrong bits, or did not clamp, would start transfers that should not exist. It changes the pins in the middle of a frame, which catches a design that sends the new data early or drops the follow-up frame. It also watches the parallel outputs on every cycle, which catches a register that tracks the shift register instead of updating once at completion.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned PM_W = 32;
  localparam int unsigned LEN_W = 6;
  localparam int unsigned LEN_MIN = 4;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_ALT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_DDR  = 2'd3;

  localparam int unsigned CTRL_SRC_BIT  = 8;
  localparam int unsigned CTRL_TRIG_BIT = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_TRAIL, ST_GAP
  } pm_state_e;

  // clamp the programmed length into the legal window
  function automatic logic [LEN_W-1:0] pm_eff_len(input logic [LEN_W-1:0] raw);
    if (raw < LEN_W'(LEN_MIN)) return LEN_W'(LEN_MIN);
    if (raw > LEN_W'(PM_W)) return LEN_W'(PM_W);
    return raw;
  endfunction

  // ones in every bit position below the frame length
  function automatic logic [PM_W-1:0] pm_len_mask(input logic [LEN_W-1:0] len);
    logic [PM_W-1:0] m;
    for (int i = 0; i < int'(PM_W); i++) m[i] = (i < int'(len));
    return m;
  endfunction
endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PM_W-1:0] pins_in,
  input  logic            bus_wen,
  input  logic [1:0]      bus_addr,
  input  logic [PM_W-1:0] bus_wdata,
  output logic [PM_W-1:0] bus_rdata,
  input  logic            start,
  input  logic            done,
  input  logic [PM_W-1:0] tx_frame,
  input  logic [PM_W-1:0] rx_frame,
  output logic [PM_W-1:0] src_frame,
  output logic [PM_W-1:0] cmp_frame,
  output logic [LEN_W-1:0] eff_len,
  output logic            trig_pend,
  output logic [PM_W-1:0] ddr_frame
);
  logic [PM_W-1:0]  samp_q, alt_q, cmp_q, ddr_q;
  logic [LEN_W-1:0] len_q;
  logic             src_q, trig_q;
  logic             wr_ctrl, wr_alt;

  assign wr_ctrl = bus_wen && (bus_addr == A_CTRL);
  assign wr_alt  = bus_wen && (bus_addr == A_ALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      alt_q  <= '0;
      cmp_q  <= '0;
      ddr_q  <= '0;
      len_q  <= LEN_W'(PM_W);
      src_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      samp_q <= pins_in;
      if (wr_ctrl) begin
        len_q <= bus_wdata[LEN_W-1:0];
        src_q <= bus_wdata[CTRL_SRC_BIT];
      end
      if (wr_alt) alt_q <= bus_wdata;
      if (wr_ctrl && bus_wdata[CTRL_TRIG_BIT]) trig_q <= 1'b1;
      else if (start)                          trig_q <= 1'b0;
      if (done) begin
        cmp_q <= tx_frame;
        ddr_q <= rx_frame;
      end
    end
  end

  assign eff_len   = pm_eff_len(len_q);
  assign src_frame = (src_q ? alt_q : samp_q) & pm_len_mask(eff_len);
  assign cmp_frame = cmp_q;
  assign trig_pend = trig_q;
  assign ddr_frame = ddr_q;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(PM_W-CTRL_SRC_BIT-1){1'b0}}, src_q,
                            {(CTRL_SRC_BIT-LEN_W){1'b0}}, len_q};
      A_ALT:   bus_rdata = alt_q;
      A_CMP:   bus_rdata = cmp_q;
      default: bus_rdata = ddr_q;
    endcase
  end

  // R7: parallel outputs only move on a completed frame
  assert_ddr_frame_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ddr_q));

  // R6: last-sent copy follows the frame the engine just finished
  assert_cmp_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cmp_q == $past(tx_frame)));

  // R6: last-sent copy holds between completions
  assert_cmp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(cmp_q));
endmodule

// File: rtl/pm_engine.sv
module pm_engine
  import pm_pkg::*;
#(
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned GAP_HALVES = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PM_W-1:0]  src_frame,
  input  logic [PM_W-1:0]  cmp_frame,
  input  logic             trig_pend,
  input  logic [LEN_W-1:0] eff_len,
  input  logic             sdi,
  output logic             sck,
  output logic             cs_n,
  output logic             sdo,
  output logic             start,
  output logic             done,
  output logic [PM_W-1:0]  tx_frame,
  output logic [PM_W-1:0]  rx_frame
);
  localparam int unsigned GAP_CYC = HALF_DIV * GAP_HALVES;
  localparam int unsigned CNT_W   = $clog2(GAP_CYC + 1);
  localparam int unsigned IDX_W   = $clog2(PM_W);

  pm_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] bit_q;
  logic [LEN_W-1:0] len_q;
  logic [PM_W-1:0]  tx_q, rx_q;
  logic             sck_q, cs_n_q, sdo_q;
  logic             frame_differs, half_end, gap_end;

  // named events for the assertions
  assign frame_differs = (src_frame != cmp_frame);
  assign start    = (state_q == ST_IDLE) && (frame_differs || trig_pend);
  assign half_end = (cnt_q == CNT_W'(HALF_DIV - 1));
  assign gap_end  = (cnt_q == CNT_W'(GAP_CYC - 1));
  assign done     = (state_q == ST_TRAIL) && half_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      len_q   <= LEN_W'(PM_W);
      tx_q    <= '0;
      rx_q    <= '0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      sdo_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) begin
            state_q <= ST_LEAD;
            cs_n_q  <= 1'b0;
            tx_q    <= src_frame;
            rx_q    <= '0;
            len_q   <= eff_len;
            bit_q   <= IDX_W'(eff_len - 1'b1);
          end
        end
        ST_LEAD: if (half_end) begin
          cnt_q   <= '0;
          state_q <= ST_HIGH;
          sck_q   <= 1'b1;
          sdo_q   <= tx_q[bit_q];
        end
        ST_HIGH: if (half_end) begin
          cnt_q   <= '0;
          sck_q   <= 1'b0;
          rx_q    <= {rx_q[PM_W-2:0], sdi};
          state_q <= (bit_q == '0) ? ST_TRAIL : ST_LOW;
        end
        ST_LOW: if (half_end) begin
          cnt_q   <= '0;
          sck_q   <= 1'b1;
          bit_q   <= bit_q - 1'b1;
          sdo_q   <= tx_q[bit_q - 1'b1];
          state_q <= ST_HIGH;
        end
        ST_TRAIL: if (half_end) begin
          cnt_q   <= '0;
          cs_n_q  <= 1'b1;
          sdo_q   <= 1'b0;
          state_q <= ST_GAP;
        end
        ST_GAP: if (gap_end) begin
          cnt_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck      = sck_q;
  assign cs_n     = cs_n_q;
  assign sdo      = sdo_q;
  assign tx_frame = tx_q;
  assign rx_frame = rx_q & pm_len_mask(len_q);

  // checker state: falling edges per frame and idle run of the select line
  logic             sck_d;
  logic [LEN_W-1:0] fall_cnt;
  logic [CNT_W-1:0] idle_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      fall_cnt <= '0;
      idle_run <= CNT_W'(GAP_CYC);
    end else begin
      sck_d <= sck_q;
      if (start)                 fall_cnt <= '0;
      else if (sck_d && !sck_q)  fall_cnt <= fall_cnt + 1'b1;
      if (!cs_n_q)                            idle_run <= '0;
      else if (idle_run != CNT_W'(GAP_CYC))   idle_run <= idle_run + 1'b1;
    end
  end

  assert_sck_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sck_q);

  assert_sdo_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> $stable(sdo_q));

  assert_start_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cs_n_q && !sck_q));

  assert_bit_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (fall_cnt == len_q));

  assert_min_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> ($past(idle_run) == CNT_W'(GAP_CYC)));
endmodule

// File: rtl/pinmirror_port.sv
module pinmirror_port
  import pm_pkg::*;
#(
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned GAP_HALVES = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PM_W-1:0] pins_in,
  output logic [PM_W-1:0] pins_out,
  input  logic            bus_wen,
  input  logic [1:0]      bus_addr,
  input  logic [PM_W-1:0] bus_wdata,
  output logic [PM_W-1:0] bus_rdata,
  output logic            sck,
  output logic            cs_n,
  output logic            sdo,
  input  logic            sdi
);
  logic             start, done, trig_pend;
  logic [PM_W-1:0]  tx_frame, rx_frame, src_frame, cmp_frame;
  logic [LEN_W-1:0] eff_len;

  pm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_in   (pins_in),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .start     (start),
    .done      (done),
    .tx_frame  (tx_frame),
    .rx_frame  (rx_frame),
    .src_frame (src_frame),
    .cmp_frame (cmp_frame),
    .eff_len   (eff_len),
    .trig_pend (trig_pend),
    .ddr_frame (pins_out)
  );

  pm_engine #(
    .HALF_DIV   (HALF_DIV),
    .GAP_HALVES (GAP_HALVES)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_frame (src_frame),
    .cmp_frame (cmp_frame),
    .trig_pend (trig_pend),
    .eff_len   (eff_len),
    .sdi       (sdi),
    .sck       (sck),
    .cs_n      (cs_n),
    .sdo       (sdo),
    .start     (start),
    .done      (done),
    .tx_frame  (tx_frame),
    .rx_frame  (rx_frame)
  );
endmodule

// File: tb/pinmirror_port_bench.sv
module pinmirror_port_bench;
  localparam int H   = 2;
  localparam int GAP = 4 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pins_in = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wen = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        sdi = 1'b0;
  logic [31:0] pins_out, bus_rdata;
  logic        sck, cs_n, sdo;

  pinmirror_port #(.HALF_DIV(H), .GAP_HALVES(4)) u_pinmirror_port (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .pins_out(pins_out),
    .bus_wen(bus_wen), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sck(sck), .cs_n(cs_n), .sdo(sdo), .sdi(sdi));

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int b_len(input int raw);
    return (raw < 4) ? 4 : ((raw > 32) ? 32 : raw);
  endfunction

  function automatic logic [31:0] b_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  // ---------------- remote-device monitor ----------------
  int cyc = 0, t_csf = 0, t_rise = 0, t_fall = 0, t_csr = 0;
  int frames = 0, nbits = 0, s_idx = 0, last_n = 0, exp_len = 32;
  logic [31:0] cap = '0, last_tx = '0, slave_word = '0, prev_out = '0;
  logic prev_cs = 1'b1, prev_sck = 1'b0, rise_sdo = 1'b0;
  bit first = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_cs && !cs_n) begin
        if (frames > 0) chk(cyc - t_csr >= GAP, "R10", "idle gap", 32'(cyc - t_csr), 32'(GAP));
        t_csf = cyc; nbits = 0; cap = '0; first = 1'b1; s_idx = exp_len - 1;
      end
      if (!prev_sck && sck) begin
        if (first) chk(cyc - t_csf == H, "R9", "select lead", 32'(cyc - t_csf), 32'(H));
        else       chk(cyc - t_fall == H, "R8", "low half", 32'(cyc - t_fall), 32'(H));
        first = 1'b0; t_rise = cyc; rise_sdo = sdo;
        if (s_idx >= 0) sdi = slave_word[s_idx];
        s_idx--;
      end
      if (prev_sck && !sck) begin
        chk(cyc - t_rise == H, "R8", "high half", 32'(cyc - t_rise), 32'(H));
        chk(sdo == rise_sdo, "R8", "sdo held while high", 32'(sdo), 32'(rise_sdo));
        cap = {cap[30:0], sdo}; nbits++; t_fall = cyc;
      end
      if (!prev_cs && cs_n) begin
        chk(cyc - t_fall == H, "R9", "select tail", 32'(cyc - t_fall), 32'(H));
        last_tx = cap; last_n = nbits; frames++; t_csr = cyc;
      end else if (pins_out !== prev_out) begin
        chk(1'b0, "R7", "pins_out moved outside completion", pins_out, prev_out);
      end
      prev_cs = cs_n; prev_sck = sck; prev_out = pins_out;
    end
  end

  // ---------------- bus helpers and model ----------------
  logic [31:0] m_pins = '0, m_alt = '0, m_cmp = '0, m_ddr = '0;
  logic [5:0]  m_len = 6'd32;
  logic        m_src = 1'b0;

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wr_ctrl(input bit trig);
    wr(2'd0, {22'b0, trig, m_src, 2'b00, m_len});
  endtask

  task automatic expect_frame(input int f0, input logic [31:0] exp_tx, input string tag);
    logic [31:0] d, exp_rx;
    int n;
    n = 0;
    while (frames <= f0 && n < 2000) begin @(negedge clk); n++; end
    chk(frames > f0, tag, "frame sent", 32'(frames - f0), 32'd1);
    exp_rx = slave_word & b_mask(b_len(int'(m_len)));
    chk(last_tx == exp_tx, tag, "frame data", last_tx, exp_tx);
    chk(last_n == b_len(int'(m_len)), "R3", "bit count", 32'(last_n), 32'(b_len(int'(m_len))));
    rd(2'd2, d);
    chk(d == exp_tx, "R6", "last-sent register", d, exp_tx);
    rd(2'd3, d);
    chk(d == exp_rx, "R7", "deserialized register", d, exp_rx);
    chk(pins_out == exp_rx, "R7", "parallel outputs", pins_out, exp_rx);
    m_cmp = exp_tx; m_ddr = exp_rx;
    repeat (GAP + 4) @(negedge clk);
  endtask

  task automatic expect_none(input int f0, input string tag);
    repeat (30) @(negedge clk);
    chk(frames == f0 && cs_n, tag, "no transfer", 32'(frames - f0), 32'd0);
    chk(pins_out == m_ddr, "R7", "outputs unchanged", pins_out, m_ddr);
  endtask

  // kind: 0 pins, 1 alternate, 2 length, 3 source, 4 trigger
  task automatic step(input int kind, input logic [31:0] val, input string tag);
    int f0;
    bit force_tx;
    logic [31:0] src;
    f0 = frames; force_tx = 1'b0;
    slave_word = $urandom;
    if (kind == 2) m_len = val[5:0];
    exp_len = b_len(int'(m_len));
    case (kind)
      0: begin m_pins = val; pins_in = val; end
      1: begin m_alt = val; wr(2'd1, val); end
      2: wr_ctrl(1'b0);
      3: begin m_src = val[0]; wr_ctrl(1'b0); end
      default: begin force_tx = 1'b1; wr_ctrl(1'b1); end
    endcase
    src = (m_src ? m_alt : m_pins) & b_mask(exp_len);
    if (src != m_cmp || force_tx) expect_frame(f0, src, tag);
    else expect_none(f0, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d, a_val, b_val;
    int f0, n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(cs_n == 1'b1 && sck == 1'b0 && sdo == 1'b0, "R11", "link idle",
        {29'b0, cs_n, sck, sdo}, 32'h4);
    chk(pins_out == 32'h0, "R11", "outputs zero", pins_out, 32'h0);
    rd(2'd0, d); chk(d == 32'h20, "R11", "control word", d, 32'h20);
    rd(2'd1, d); chk(d == 32'h0, "R11", "alternate", d, 32'h0);
    rd(2'd2, d); chk(d == 32'h0, "R11", "last-sent", d, 32'h0);

    // R4: zero pins match the reset copy, nothing is sent
    f0 = frames; expect_none(f0, "R4");

    step(0, 32'hA5C3_1E07, "R1");                 // live pins sent MSB first
    step(0, 32'hA5C3_1E07, "R4");                 // unchanged: no frame
    step(4, 32'h0, "R5");                         // forced resend
    rd(2'd0, d); chk(d[9] == 1'b0, "R5", "trigger reads 0", d, 32'h20);
    step(2, 32'd8, "R3");                         // 8-bit frame
    step(0, 32'hA5C3_1E07 ^ 32'hFFFF_FF00, "R3"); // upper bits ignored
    step(2, 32'd2, "R3");                         // clamps to 4, same masked data
    step(2, 32'd50, "R3");                        // clamps to 32
    step(1, 32'h3C3C_9001, "R2");                 // alternate not selected
    step(3, 32'd1, "R2");                         // switch to alternate
    step(0, 32'h0F0F_0F0F, "R2");                 // pins ignored now
    step(3, 32'd0, "R1");                         // back to live pins

    // R10: pins change mid-frame, two frames follow with a proper gap
    f0 = frames; slave_word = $urandom; exp_len = b_len(int'(m_len));
    a_val = 32'h1234_5678; b_val = 32'h8765_4321;
    pins_in = a_val; n = 0;
    while (cs_n && n < 50) begin @(negedge clk); n++; end
    pins_in = b_val; m_pins = b_val;
    n = 0; while (frames <= f0 && n < 2000) begin @(negedge clk); n++; end
    chk(last_tx == (a_val & b_mask(exp_len)), "R10", "first frame", last_tx, a_val & b_mask(exp_len));
    n = 0; while (frames <= f0 + 1 && n < 2000) begin @(negedge clk); n++; end
    chk(last_tx == (b_val & b_mask(exp_len)), "R10", "follow-up frame", last_tx, b_val & b_mask(exp_len));
    m_cmp = b_val & b_mask(exp_len); m_ddr = slave_word & b_mask(exp_len);
    repeat (GAP + 4) @(negedge clk);
    chk(pins_out == m_ddr, "R7", "outputs after pair", pins_out, m_ddr);

    // constrained random single actions
    for (int i = 0; i < 40; i++) begin
      int kind;
      logic [31:0] v;
      kind = int'($urandom % 5);
      v = $urandom;
      if (kind == 0 && v[0]) v = m_pins ^ (32'h1 << ($urandom % 32));
      if (kind == 2) v = $urandom % 64;
      step(kind, v, "R4");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule